// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Calculator

This block turns a pixel clock frequency and an audio sample rate, both in Hz, into the N and CTS pair that a display transmitter sends so that the sink can rebuild its audio clock. A start pulse captures the inputs. The block then computes the ratio 128·fs / pixel clock and reduces it by its greatest common divisor, found by repeated subtraction. Next it scales the pair so that 128·fs/N comes close to 1 kHz. Finally it folds the double and quadruple sample rates back into their base rate family. One done pulse returns N, the shifted CTS register field, a rate-group code, an N multiple, a layout bit and a packed packet-control word.

The block is meant to sit beside a transmitter's audio packet engine and run once when the audio format or the video mode changes. The run time depends on the data. The subtract-based reduction takes roughly as many steps as the quotients of the Euclidean sequence add up to, and four 32-step restoring divisions follow it.

Top module: `acr_calc`

## Requirements
- R1: With g = gcd(128·fs, pclk), Nr = 128·fs/g and Cr = pclk/g, the scale is m = floor((floor(128·fs/1000) + Nr − 1) / Nr). N = Nr·m and CTS = Cr·m, both truncated to 32 bits, before the adjustment of R2.
- R2: For fs of 88200 or 96000, N is shifted right by 1 and n_mult_o is 2. For 176400 or 192000, N is shifted right by 2 and n_mult_o is 4. Every other rate gives n_mult_o 1 with no shift.
- R3: rate_code_o is 2 for 44100, 88200 and 176400, 3 for 48000, 96000 and 192000, and 1 for any other rate, 32000 included.
- R4: cts_o equals CTS shifted left by 12, truncated to 32 bits.
- R5: pkt_ctrl_o has bit 31 set, bit 8 set, bits 1:0 = 2'b11, bits 5:4 = rate code and bits 18:16 = N multiple. All other bits are 0.
- R6: When num_ch_i is 0, the block uses fs = 48000 and 2 channels, whatever fs_hz_i holds.
- R7: layout_o is 0 when the effective channel count is exactly 2, and 1 otherwise.
- R8: done_o is high for exactly one cycle per accepted start. All result outputs hold their values until the next done_o.
- R9: busy_o is high from the cycle after an accepted start until done_o. A start_i pulse while busy_o is high is ignored, and the result reflects the inputs of the accepted start.
- R10: A pclk_hz_i of 0, or an effective fs of 0, ends with done_o and err_o set. n_o, cts_o, rate_code_o, n_mult_o, layout_o and pkt_ctrl_o are then all 0.
- R11: After reset, done_o, busy_o, err_o and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; inputs captured on this edge when idle |
| pclk_hz_i | input | 32 | Pixel clock in Hz |
| fs_hz_i | input | 32 | Audio sample rate in Hz |
| num_ch_i | input | 4 | Requested channel count, 0 selects defaults |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run rejected a zero clock or rate |
| n_o | output | 32 | N value |
| cts_o | output | 32 | CTS register field (CTS << 12) |
| rate_code_o | output | 2 | Rate-group code |
| n_mult_o | output | 3 | N multiple |
| layout_o | output | 1 | Channel layout bit |
| pkt_ctrl_o | output | 32 | Packed packet-control word |

## Verification
The hardest case to create from the ports is a second start that arrives while the subtraction loop or a division is still running. It has to be shown to leave no mark on the result. The stimulus starts one run, changes every input and pulses start again a few cycles later, then compares the finished result against the model for the first input set. A per-clock monitor also checks that the results never change outside a done pulse. The vectors cover all seven standard rates, an unknown rate, the zero-channel default and both zero-input errors.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GCD, ST_DIV_N, ST_DIV_C, ST_DIV_T, ST_DIV_M, ST_FIN
  } acr_state_e;

  localparam int unsigned DEF_FS_HZ  = 48000;
  localparam int unsigned FS_SCALE_SH = 7;     // x128
  localparam int unsigned TARGET_HZ  = 1000;
  localparam int unsigned CTS_SH     = 12;
endpackage

// File: rtl/acr_gcd.sv
module acr_gcd #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] g_o
);
  logic [W-1:0] a_q, b_q, g_q;
  logic         run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; g_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        a_q <= a_i; b_q <= b_i; run_q <= 1'b1;
      end else if (run_q) begin
        if (b_q == '0) begin
          g_q <= a_q; done_q <= 1'b1; run_q <= 1'b0;
        end else if (a_q < b_q) begin
          a_q <= b_q; b_q <= a_q;
        end else begin
          a_q <= a_q - b_q;
        end
      end
    end
  end

  assign done_o = done_q;
  assign g_o    = g_q;

  // R1
  gcd_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> g_q != '0);
endmodule

// File: rtl/acr_div.sv
module acr_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W:0]       rem_q, rem_sh, diff;
  logic [W-1:0]     quo_q, dvs_q, dvd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0; dvd_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0; quo_q <= dvd_i; dvs_q <= dvs_i; dvd_q <= dvd_i;
        cnt_q <= CNT_W'(W); run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= diff[W] ? rem_sh : diff;
        quo_q <= {quo_q[W-2:0], ~diff[W]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0; done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  // R1
  div_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && dvs_q != '0) |->
      ((2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q) == (2*W)'(dvd_q))
      && (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/acr_rate_map.sv
module acr_rate_map #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] fs_i,
  output logic [1:0]   code_o,
  output logic [2:0]   mult_o,
  output logic [1:0]   shift_o
);
  always_comb begin
    code_o = 2'd1; mult_o = 3'd1; shift_o = 2'd0;
    case (fs_i)
      W'(44100):  begin code_o = 2'd2; end
      W'(48000):  begin code_o = 2'd3; end
      W'(88200):  begin code_o = 2'd2; mult_o = 3'd2; shift_o = 2'd1; end
      W'(96000):  begin code_o = 2'd3; mult_o = 3'd2; shift_o = 2'd1; end
      W'(176400): begin code_o = 2'd2; mult_o = 3'd4; shift_o = 2'd2; end
      W'(192000): begin code_o = 2'd3; mult_o = 3'd4; shift_o = 2'd2; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acr_calc.sv
module acr_calc
  import acr_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [W-1:0]    pclk_hz_i,
  input  logic [W-1:0]    fs_hz_i,
  input  logic [CH_W-1:0] num_ch_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [W-1:0]    n_o,
  output logic [W-1:0]    cts_o,
  output logic [1:0]      rate_code_o,
  output logic [2:0]      n_mult_o,
  output logic            layout_o,
  output logic [31:0]     pkt_ctrl_o
);
  acr_state_e   state_q;
  logic [W-1:0] fs_eff, fs_q, pclk_q, n0_q, g_q, n_q, cts_q, mul_q;
  logic [W-1:0] div_a_q, div_b_q, n_scaled, cts_scaled, n_fin, cts_fld;
  logic         layout_q, err_q, gcd_go_q, div_go_q, done_q;
  logic         gcd_done, div_done;
  logic [W-1:0] gcd_g, div_quot;
  logic [1:0]   code, shift;
  logic [2:0]   mult;
  logic [31:0]  pkt;

  logic [W-1:0]  n_oq, cts_oq;
  logic [1:0]    code_oq;
  logic [2:0]    mult_oq;
  logic          layout_oq, err_oq;
  logic [31:0]   pkt_oq;

  assign fs_eff = (num_ch_i == '0) ? W'(DEF_FS_HZ) : fs_hz_i;

  acr_gcd #(.W(W)) gcd_i (
    .clk_i, .rst_ni, .go_i(gcd_go_q), .a_i(n0_q), .b_i(pclk_q),
    .done_o(gcd_done), .g_o(gcd_g)
  );

  acr_div #(.W(W)) div_i (
    .clk_i, .rst_ni, .go_i(div_go_q), .dvd_i(div_a_q), .dvs_i(div_b_q),
    .done_o(div_done), .quot_o(div_quot)
  );

  acr_rate_map #(.W(W)) map_i (
    .fs_i(fs_q), .code_o(code), .mult_o(mult), .shift_o(shift)
  );

  always_comb begin
    n_scaled   = n_q * mul_q;
    cts_scaled = cts_q * mul_q;
    n_fin      = n_scaled >> shift;
    cts_fld    = cts_scaled << CTS_SH;
    pkt        = '0;
    pkt[31]    = 1'b1;
    pkt[8]     = 1'b1;
    pkt[18:16] = mult;
    pkt[5:4]   = code;
    pkt[1:0]   = 2'b11;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fs_q <= '0; pclk_q <= '0; n0_q <= '0; g_q <= '0; n_q <= '0;
      cts_q <= '0; mul_q <= '0; div_a_q <= '0; div_b_q <= '0;
      layout_q <= 1'b0; err_q <= 1'b0;
      gcd_go_q <= 1'b0; div_go_q <= 1'b0; done_q <= 1'b0;
      n_oq <= '0; cts_oq <= '0; code_oq <= '0; mult_oq <= '0;
      layout_oq <= 1'b0; err_oq <= 1'b0; pkt_oq <= '0;
    end else begin
      gcd_go_q <= 1'b0;
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          fs_q     <= fs_eff;
          pclk_q   <= pclk_hz_i;
          n0_q     <= fs_eff << FS_SCALE_SH;
          layout_q <= (num_ch_i != '0) && (num_ch_i != CH_W'(2));
          if (pclk_hz_i == '0 || fs_eff == '0) begin
            err_q <= 1'b1; state_q <= ST_FIN;
          end else begin
            err_q <= 1'b0; gcd_go_q <= 1'b1; state_q <= ST_GCD;
          end
        end
        ST_GCD: if (gcd_done) begin
          g_q <= gcd_g; div_a_q <= n0_q; div_b_q <= gcd_g;
          div_go_q <= 1'b1; state_q <= ST_DIV_N;
        end
        ST_DIV_N: if (div_done) begin
          n_q <= div_quot; div_a_q <= pclk_q; div_b_q <= g_q;
          div_go_q <= 1'b1; state_q <= ST_DIV_C;
        end
        ST_DIV_C: if (div_done) begin
          cts_q <= div_quot; div_a_q <= n0_q; div_b_q <= W'(TARGET_HZ);
          div_go_q <= 1'b1; state_q <= ST_DIV_T;
        end
        ST_DIV_T: if (div_done) begin
          div_a_q <= div_quot + n_q - 1'b1; div_b_q <= n_q;  // ceil
          div_go_q <= 1'b1; state_q <= ST_DIV_M;
        end
        ST_DIV_M: if (div_done) begin
          mul_q <= div_quot; state_q <= ST_FIN;
        end
        ST_FIN: begin
          err_oq    <= err_q;
          n_oq      <= err_q ? '0 : n_fin;
          cts_oq    <= err_q ? '0 : cts_fld;
          code_oq   <= err_q ? '0 : code;
          mult_oq   <= err_q ? '0 : mult;
          pkt_oq    <= err_q ? '0 : pkt;
          layout_oq <= err_q ? 1'b0 : layout_q;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_oq;
  assign n_o         = n_oq;
  assign cts_o       = cts_oq;
  assign rate_code_o = code_oq;
  assign n_mult_o    = mult_oq;
  assign layout_o    = layout_oq;
  assign pkt_ctrl_o  = pkt_oq;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(n_o) && $stable(cts_o) && $stable(pkt_ctrl_o))));
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(fs_q) && $stable(pclk_q)));
  // R10
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (n_o == '0 && cts_o == '0 && pkt_ctrl_o == '0));
  // R5
  pkt_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (pkt_ctrl_o[5:4] == rate_code_o
      && pkt_ctrl_o[18:16] == n_mult_o && pkt_ctrl_o[31] && pkt_ctrl_o[8]));
  // R2
  mult_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($countones(n_mult_o) == 1 && !n_mult_o[0] == (rate_code_o != 2'd1 && n_mult_o != 3'd1)));
endmodule

// File: tb/acr_calc_tb.sv
`timescale 1ns/1ps
module acr_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pclk = '0, fs = '0;
  logic [3:0]  ch = '0;
  logic        busy, done, err, layout;
  logic [31:0] n, cts, pkt;
  logic [1:0]  code;
  logic [2:0]  mult;
  int          n_chk = 0, n_fail = 0;
  longint      cyc = 0;

  always #2 clk = ~clk;

  acr_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pclk_hz_i(pclk),
    .fs_hz_i(fs), .num_ch_i(ch), .busy_o(busy), .done_o(done), .err_o(err),
    .n_o(n), .cts_o(cts), .rate_code_o(code), .n_mult_o(mult),
    .layout_o(layout), .pkt_ctrl_o(pkt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock monitor: done is a single pulse, results hold between pulses
  logic        prev_done = 1'b0;
  logic [31:0] prev_n = '0, prev_cts = '0, prev_pkt = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(!(prev_done && done), "R8", "done width", 64'(done), 0);
      if (!done)
        chk(n == prev_n && cts == prev_cts && pkt == prev_pkt, "R8", "hold",
            longint'(n), longint'(prev_n));
    end
    prev_done = done; prev_n = n; prev_cts = cts; prev_pkt = pkt;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic longint gcd_f(input longint a, input longint b);
    longint t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  typedef struct {
    bit e; longint n, c; int code, mult; bit lay; longint pkt;
  } exp_t;

  function automatic exp_t model(input longint pc, input longint f, input int chn);
    exp_t r;
    longint fe, n0, g, nr, cr, t, m;
    int sh;
    r = '{default: 0};
    fe = (chn == 0) ? 48000 : f;
    if (pc == 0 || fe == 0) begin r.e = 1; return r; end
    r.lay = (chn != 0 && chn != 2);
    n0 = (fe * 128) & 64'hFFFF_FFFF;
    g = gcd_f(n0, pc);
    nr = n0 / g; cr = pc / g;
    t = n0 / 1000;
    m = ((t + nr - 1) & 64'hFFFF_FFFF) / nr;
    nr = (nr * m) & 64'hFFFF_FFFF;
    cr = (cr * m) & 64'hFFFF_FFFF;
    r.code = 1; r.mult = 1; sh = 0;
    if (fe == 44100 || fe == 88200 || fe == 176400) r.code = 2;
    if (fe == 48000 || fe == 96000 || fe == 192000) r.code = 3;
    if (fe == 88200 || fe == 96000) begin r.mult = 2; sh = 1; end
    if (fe == 176400 || fe == 192000) begin r.mult = 4; sh = 2; end
    r.n = nr >> sh;
    r.c = (cr << 12) & 64'hFFFF_FFFF;
    r.pkt = (64'h1 << 31) | (64'h1 << 8) | (longint'(r.code) << 4)
          | (longint'(r.mult) << 16) | 64'h3;
    return r;
  endfunction

  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done, "R8", "done seen", 64'(done), 1);
  endtask

  task automatic compare(input exp_t x, input string tag);
    chk(err == x.e, "R10", {tag, " err"}, 64'(err), 64'(x.e));
    chk(n == x.n, "R1", {tag, " n"}, longint'(n), x.n);
    chk(cts == x.c, "R4", {tag, " cts"}, longint'(cts), x.c);
    chk(code == x.code, "R3", {tag, " code"}, longint'(code), longint'(x.code));
    chk(mult == x.mult, "R2", {tag, " mult"}, longint'(mult), longint'(x.mult));
    chk(pkt == x.pkt, "R5", {tag, " pkt"}, longint'(pkt), x.pkt);
    chk(layout == x.lay, "R7", {tag, " layout"}, longint'(layout), longint'(x.lay));
  endtask

  task automatic run_case(input longint pc, input longint f, input int chn, input string tag);
    exp_t x = model(pc, f, chn);
    @(negedge clk);
    pclk = 32'(pc); fs = 32'(f); ch = 4'(chn); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!x.e) chk(busy, "R9", {tag, " busy"}, 64'(busy), 1);
    wait_done();
    compare(x, tag);
    @(negedge clk);
    chk(!done, "R8", {tag, " done drop"}, 64'(done), 0);
    compare(x, {tag, " held"});
  endtask

  initial begin
    exp_t x;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !busy && !err, "R11", "flags", 64'({done, busy, err}), 0);
    chk(n == 0 && cts == 0 && pkt == 0 && code == 0 && mult == 0 && !layout,
        "R11", "outputs", longint'(pkt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(74250000, 48000, 2, "R1 48k");
    run_case(148500000, 44100, 8, "R7 44k1 8ch");
    run_case(25200000, 32000, 2, "R3 32k");
    run_case(297000000, 96000, 6, "R2 96k");
    run_case(74250000, 88200, 2, "R2 88k2");
    run_case(594000000, 192000, 2, "R2 192k");
    run_case(27000000, 176400, 3, "R2 176k4");
    run_case(74250000, 22050, 2, "R3 unknown");
    run_case(148500000, 12345, 0, "R6 default");
    run_case(0, 48000, 2, "R10 pclk0");
    run_case(74250000, 0, 2, "R10 fs0");

    // R9: second start while busy is ignored
    x = model(74250000, 44100, 2);
    @(negedge clk);
    pclk = 32'd74250000; fs = 32'd44100; ch = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R9", "busy before restart", 64'(busy), 1);
    pclk = 32'd25200000; fs = 32'd192000; ch = 4'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare(x, "R9 ignore");
    @(negedge clk);
    chk(!busy, "R9", "idle after", 64'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule